// File: doc/BRIEF.md
# Multiplier-Free Row-Major Address Walker

This block walks a two-dimensional image array row by row and, for every element, presents two addresses at once. The first is a word address into off-chip memory. The second is an address into a small on-chip circular line buffer. Neither address uses a multiplier. Rows are laid out on a padded pitch: the smallest power of two that covers the largest allowed column count. A row start is therefore a shift of the row index, or a running base register that gains one pitch per row. The line-buffer address is just the low bits of the row index placed in front of the column index.

A start pulse captures the run-time column and row counts. The walker then offers one element per handshake on a ready/valid pair. A two-bit row-offset input lets a sliding-window consumer reach the row above or below the current one. That offset is clamped at the top and bottom edges of the image. A one-cycle done pulse marks the end of the walk. A parameter selects how the row base is formed: an incremental register or a shift of the row index. Both choices give the same addresses.

Top module: `addr_walker`

## Requirements
- R1: A start pulse while idle, with 1 <= cols <= MAX_COLS and 1 <= rows <= MAX_ROWS, makes out_valid rise at the next clock edge, presenting element (row 0, column 0). A start while a walk is in progress, or with a zero or oversized count, is ignored and leaves out_valid low when idle.
- R2: Elements are offered in row-major order. Each accepted handshake (out_valid and out_ready both high) advances the column by one. After column cols-1 the column returns to 0 and the row advances by one.
- R3: ext_addr equals BASE_ADDR + eff_row * PITCH + column, where PITCH = 2^ceil(log2(MAX_COLS)). The pitch is 512 for the default MAX_COLS of 512, and it does not depend on the run-time column count.
- R4: row_ofs selects the effective row. 2'b00 and 2'b10 select the current row, 2'b01 selects the next row and 2'b11 selects the previous row. A step past row 0 or past row rows-1 is clamped to that edge row.
- R5: buf_addr equals {eff_row[LINE_BITS-1:0], column[PW-1:0]} with PW = log2(PITCH). The line buffer therefore holds 2^LINE_BITS rows, mapped circularly.
- R6: While out_valid is high and out_ready is low, out_valid stays high and the offered element does not change.
- R7: done is high for exactly one cycle, in the cycle after the handshake on the last element of the last row. out_valid is low in that same cycle.
- R8: Instances with INCR_MODE=1 (running row base) and INCR_MODE=0 (shifted row index) produce identical ext_addr and buf_addr for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk using cols and rows |
| cols | input | CW (10) | Column count for the walk |
| rows | input | RW (10) | Row count for the walk |
| row_ofs | input | 2 | Neighbour row select (see R4) |
| out_ready | input | 1 | Consumer accepts the offered element |
| out_valid | output | 1 | An element is offered |
| ext_addr | output | ADDR_W (18) | Off-chip word address |
| buf_addr | output | LINE_BITS+PW (11) | Circular line-buffer address |
| done | output | 1 | One-cycle pulse after the last element |

## Verification
The bound checker checks several properties on every cycle. It recomputes ext_addr from the walker position with the edge clamp applied. It checks that the column of the offered element stays below the captured column count. It checks that both output addresses carry the same column and that the buffer row bits match the row encoded in ext_addr. It also checks that an offered element is held under back-pressure and that done lasts one cycle and follows a handshake. Some behaviour is visible only in the bench scenarios: the exact row-major order, the rejection of bad or overlapping starts, done timing across whole walks of several shapes, and the match between the two row-base modes.

// File: rtl/addr_walker.sv
module addr_walker #(
  parameter int MAX_COLS   = 512,
  parameter int MAX_ROWS   = 512,
  parameter int LINE_BITS  = 2,
  parameter bit INCR_MODE  = 1'b1,
  parameter int ADDR_W     = $clog2(MAX_ROWS) + $clog2(MAX_COLS),
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  localparam int PW  = $clog2(MAX_COLS),
  localparam int CW  = PW + 1,
  localparam int RIW = $clog2(MAX_ROWS),
  localparam int RW  = RIW + 1,
  localparam int BW  = LINE_BITS + PW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     cols,
  input  logic [RW-1:0]     rows,
  input  logic [1:0]        row_ofs,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [BW-1:0]     buf_addr,
  output logic              done
);
  localparam logic [ADDR_W-1:0] PITCH = ADDR_W'(1) << PW;

  logic           busy_q, done_q;
  logic [CW-1:0]  cols_q;
  logic [RIW-1:0] lastrow_q, row_q, eff_row;
  logic [PW-1:0]  col_q;
  logic [ADDR_W-1:0] rel;
  logic launch, fire, col_end, row_end, go_up, go_dn, size_ok;

  assign size_ok = (cols != '0) && (cols <= CW'(MAX_COLS)) &&
                   (rows != '0) && (rows <= RW'(MAX_ROWS));
  assign launch  = start && !busy_q && size_ok;
  assign fire    = busy_q && out_ready;
  assign col_end = {1'b0, col_q} == (cols_q - CW'(1));
  assign row_end = row_q == lastrow_q;
  assign go_dn   = (row_ofs == 2'b01) && !row_end;
  assign go_up   = (row_ofs == 2'b11) && (row_q != '0);
  assign eff_row = go_dn ? row_q + RIW'(1) : go_up ? row_q - RIW'(1) : row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      cols_q    <= '0;
      lastrow_q <= '0;
      row_q     <= '0;
      col_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        busy_q    <= 1'b1;
        cols_q    <= cols;
        lastrow_q <= RIW'(rows - RW'(1));
        row_q     <= '0;
        col_q     <= '0;
      end else if (fire) begin
        if (col_end) begin
          col_q <= '0;
          if (row_end) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            row_q <= row_q + RIW'(1);
          end
        end else begin
          col_q <= col_q + PW'(1);
        end
      end
    end
  end

  if (INCR_MODE) begin : g_incr
    logic [ADDR_W-1:0] rbase_q;
    always_ff @(posedge clk) begin
      if (!rst_n || launch)
        rbase_q <= '0;
      else if (fire && col_end && !row_end)
        rbase_q <= rbase_q + PITCH;
    end
    assign rel = go_dn ? rbase_q + PITCH : go_up ? rbase_q - PITCH : rbase_q;
  end else begin : g_shift
    assign rel = ADDR_W'(eff_row) << PW;
  end

  assign out_valid = busy_q;
  assign done      = done_q;
  assign ext_addr  = BASE_ADDR + rel + ADDR_W'(col_q);
  assign buf_addr  = {eff_row[LINE_BITS-1:0], col_q};
endmodule

// File: rtl/addr_walker_check.sv
module addr_walker_check #(
  parameter int MAX_COLS  = 512,
  parameter int MAX_ROWS  = 512,
  parameter int LINE_BITS = 2,
  parameter int ADDR_W    = 18,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  localparam int PW  = $clog2(MAX_COLS),
  localparam int CW  = PW + 1,
  localparam int RIW = $clog2(MAX_ROWS),
  localparam int BW  = LINE_BITS + PW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic              done,
  input logic [1:0]        row_ofs,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [BW-1:0]     buf_addr,
  input logic [RIW-1:0]    row_q,
  input logic [RIW-1:0]    lastrow_q,
  input logic [PW-1:0]     col_q,
  input logic [CW-1:0]     cols_q
);
  logic [RIW-1:0]    exp_row;
  logic [ADDR_W-1:0] off;

  always_comb begin
    exp_row = row_q;
    if (row_ofs == 2'b01 && row_q < lastrow_q) exp_row = row_q + RIW'(1);
    if (row_ofs == 2'b11 && row_q > '0)        exp_row = row_q - RIW'(1);
  end
  assign off = ext_addr - BASE_ADDR;

  assert_valid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(col_q) && $stable(row_q));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready) && !out_valid);
  assert_ext_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ext_addr == BASE_ADDR + (ADDR_W'(exp_row) << PW) + ADDR_W'(col_q));
  assert_col_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> {1'b0, col_q} < cols_q);
  assert_buf_matches_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> buf_addr[PW-1:0] == off[PW-1:0] &&
                  buf_addr[BW-1:PW] == off[PW +: LINE_BITS]);
endmodule

bind addr_walker addr_walker_check #(
  .MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS), .LINE_BITS(LINE_BITS),
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .done(done), .row_ofs(row_ofs), .ext_addr(ext_addr), .buf_addr(buf_addr),
  .row_q(row_q), .lastrow_q(lastrow_q), .col_q(col_q), .cols_q(cols_q)
);

// File: tb/sim_addr_walker.sv
module sim_addr_walker;
  localparam int AW = 18;
  localparam logic [AW-1:0] BASE = 18'h04000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [9:0] cols = '0, rows = '0;
  logic [1:0] row_ofs = 2'b00;
  logic v0, v1, d0, d1;
  logic [AW-1:0] e0, e1;
  logic [10:0] b0, b1;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  addr_walker #(.INCR_MODE(1'b1), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cols(cols), .rows(rows),
    .row_ofs(row_ofs), .out_ready(out_ready), .out_valid(v0),
    .ext_addr(e0), .buf_addr(b0), .done(d0));
  addr_walker #(.INCR_MODE(1'b0), .BASE_ADDR(BASE)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .cols(cols), .rows(rows),
    .row_ofs(row_ofs), .out_ready(out_ready), .out_valid(v1),
    .ext_addr(e1), .buf_addr(b1), .done(d1));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(v0 == 1'b0, "R1 reset valid", v0, 0);
    chk(d0 == 1'b0, "R7 reset done", d0, 0);
  endtask

  task automatic bad_start(input int nc, input int nr);
    @(negedge clk);
    cols = 10'(nc); rows = 10'(nr); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) begin
      chk(v0 == 1'b0, "R1 ignored start valid", v0, 0);
      chk(d0 == 1'b0, "R1 ignored start done", d0, 0);
      @(negedge clk);
    end
  endtask

  // stall: 0 none, 1 every third cycle low; poke: start pulse mid-walk
  task automatic walk(input int nc, input int nr, input int stall, input bit poke);
    int i = 0, j = 0, k = 0, cyc = 0;
    bit rdy, expect_done = 0, finished_walk = 0;
    @(negedge clk);
    cols = 10'(nc); rows = 10'(nr); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(v0 == 1'b1, "R1 valid after start", v0, 1);
    while (!finished_walk) begin
      logic [1:0] code;
      int er;
      longint ee, eb;
      if (expect_done) begin
        #1;
        chk(d0 == 1'b1, "R7 done pulse", d0, 1);
        chk(v0 == 1'b0, "R7 valid low at done", v0, 0);
        out_ready = 1'b0;
        @(negedge clk);
        chk(d0 == 1'b0, "R7 done one cycle", d0, 0);
        finished_walk = 1;
      end else begin
        case (k % 4)
          0: code = 2'b00;
          1: code = 2'b01;
          2: code = 2'b11;
          default: code = 2'b10;
        endcase
        row_ofs = code;
        start = (poke && cyc == 3);
        if (poke && cyc == 3) begin cols = 10'd2; rows = 10'd2; end
        #1;
        er = i;
        if (code == 2'b01 && i < nr - 1) er = i + 1;
        if (code == 2'b11 && i > 0) er = i - 1;
        ee = longint'(BASE) + longint'(er) * 512 + j;
        eb = longint'(er % 4) * 512 + j;
        chk(v0 == 1'b1, "R6 valid held", v0, 1);
        chk(longint'(e0) == ee, $sformatf("R3 R4 ext row %0d col %0d", i, j), e0, ee);
        chk(longint'(b0) == eb, "R5 buf addr", b0, eb);
        chk(e1 == e0 && b1 == b0 && v1 == v0, "R8 mode match", e1, e0);
        rdy = (stall == 0) || (cyc % 3 != 1);
        out_ready = rdy;
        if (rdy) begin
          if (i == nr - 1 && j == nc - 1) expect_done = 1;
          else if (j == nc - 1) begin j = 0; i++; end
          else j++;
        end
        k++; cyc++;
        @(negedge clk);
        start = 1'b0;
      end
    end
    row_ofs = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    rst_n = 1'b1;
    test_reset();
    bad_start(0, 4);
    bad_start(513, 4);
    bad_start(4, 0);
    walk(5, 6, 0, 0);
    walk(5, 6, 1, 1);
    walk(1, 1, 0, 0);
    walk(3, 9, 1, 0);
    walk(512, 3, 0, 0);
    test_reset();
    summary();
  end
endmodule